// File: doc/BRIEF.md
# Indirect Message-Bus Register Bridge

This block lets software reach an internal message bus through three 32-bit registers in function 0 configuration space. The registers are a command word at D0h, a mailbox at D4h and an offset extension at D8h. To write a message-bus register, software first loads the mailbox with the value and the extension with the upper offset bits. It then writes the command word, which holds the opcode, the target port, the low offset byte and the byte enables. That command write launches one request on a simple valid/ready request port. The block then waits for a single response beat. A read response is placed in the mailbox, where software collects it.

Only a command-word write starts a transaction. While a transaction is outstanding the bridge reports busy. A further command-word write in that period is held off with a stall signal until the response has arrived. All request fields are captured at launch, so software may refill the mailbox or the extension register while the bus works.

Top module: `msgbus_cfg_bridge`

## Requirements
- R1: After reset the command word, mailbox and extension read as zero, busy is low and no request is presented.
- R2: A read at D0h returns the command word with bits 3:0 as zero. D4h returns the mailbox, D8h returns the extension with bits 7:0 as zero, and any other offset returns zero. A write to any other offset changes nothing.
- R3: A command-word write accepted while idle raises the request valid on the next cycle. Valid stays high until the cycle in which ready is sampled high.
- R4: The request carries the opcode from command bits 31:24, the port from bits 23:16 and the byte enables from bits 7:4. Its 32-bit offset is extension bits 31:8 above command bits 15:8.
- R5: For opcode 11h (write) the request data is the mailbox value at launch. For every other opcode the request data is zero.
- R6: For opcode 10h (read), the response data replaces the mailbox in the cycle the response is taken. It wins over a mailbox write in that same cycle.
- R7: For any opcode other than 10h, including unknown opcodes passed through unchanged, the response leaves the mailbox unchanged.
- R8: Writes to the mailbox or the extension never start a transaction and never raise busy.
- R9: A command-word write while busy raises the stall output in that cycle. The command word is not updated and no request is launched.
- R10: Busy is high from the cycle after launch through the cycle in which the response is taken. A response valid seen while no request has been accepted is ignored.
- R11: Request opcode, port, offset, byte enables and data stay constant for the whole transaction, even when the mailbox or extension is rewritten meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| cfg_stall | output | 1 | Command write refused while busy |
| mb_busy | output | 1 | Transaction outstanding |
| mb_req_vld | output | 1 | Request valid |
| mb_req_rdy | input | 1 | Request accepted by the bus |
| mb_opcode | output | 8 | Request opcode |
| mb_port | output | 8 | Request target port |
| mb_offset | output | 32 | Request register offset |
| mb_be | output | 4 | Request byte enables |
| mb_wdata | output | 32 | Request write data |
| mb_rsp_vld | input | 1 | Response beat |
| mb_rsp_data | input | 32 | Response data |

## Verification
The main function is driven with three transaction kinds: a write opcode with ready held back for several cycles, a read opcode accepted at once, and an unknown opcode. Together these separate the data-sourcing, data-sinking and pass-through paths. While transactions are outstanding, the mailbox and extension are rewritten and a second command is attempted, which shows whether request fields were captured or left live and whether stalling works. Stray responses while idle, writes to unused offsets and extension-only writes check that nothing but an accepted command launches or changes state.

// File: rtl/msgbus_cfg_bridge.sv
module msgbus_cfg_bridge #(
  parameter int AW = 8,
  parameter logic [AW-1:0] CMD_OFS = 8'hD0,
  parameter logic [AW-1:0] BOX_OFS = 8'hD4,
  parameter logic [AW-1:0] EXT_OFS = 8'hD8,
  parameter logic [7:0] OP_READ  = 8'h10,
  parameter logic [7:0] OP_WRITE = 8'h11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          cfg_stall,
  output logic          mb_busy,
  output logic          mb_req_vld,
  input  logic          mb_req_rdy,
  output logic [7:0]    mb_opcode,
  output logic [7:0]    mb_port,
  output logic [31:0]   mb_offset,
  output logic [3:0]    mb_be,
  output logic [31:0]   mb_wdata,
  input  logic          mb_rsp_vld,
  input  logic [31:0]   mb_rsp_data
);
  typedef enum logic [1:0] {IDLE, ISSUE, AWAIT} st_t;
  st_t st;

  logic [31:4] cmd_q;
  logic [31:0] box_q;
  logic [31:8] ext_q;
  logic [7:0]  op_q, port_q;
  logic [31:0] ofs_q, wd_q;
  logic [3:0]  be_q;

  wire hit_cmd = cfg_wr && cfg_addr == CMD_OFS;
  wire hit_box = cfg_wr && cfg_addr == BOX_OFS;
  wire hit_ext = cfg_wr && cfg_addr == EXT_OFS;
  wire launch  = hit_cmd && st == IDLE;
  wire take    = st == AWAIT && mb_rsp_vld;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= IDLE;
    else case (st)
      IDLE:    if (launch) st <= ISSUE;
      ISSUE:   if (mb_req_rdy) st <= AWAIT;
      AWAIT:   if (mb_rsp_vld) st <= IDLE;
      default: st <= IDLE;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_q <= '0;
      box_q <= '0;
      ext_q <= '0;
    end else begin
      if (launch) cmd_q <= cfg_wdata[31:4];
      if (hit_ext) ext_q <= cfg_wdata[31:8];
      if (take && op_q == OP_READ) box_q <= mb_rsp_data;
      else if (hit_box) box_q <= cfg_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      op_q <= '0; port_q <= '0; ofs_q <= '0; be_q <= '0; wd_q <= '0;
    end else if (launch) begin
      op_q   <= cfg_wdata[31:24];
      port_q <= cfg_wdata[23:16];
      ofs_q  <= {ext_q, cfg_wdata[15:8]};
      be_q   <= cfg_wdata[7:4];
      wd_q   <= (cfg_wdata[31:24] == OP_WRITE) ? box_q : '0;
    end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == CMD_OFS)      cfg_rdata = {cmd_q, 4'b0};
    else if (cfg_addr == BOX_OFS) cfg_rdata = box_q;
    else if (cfg_addr == EXT_OFS) cfg_rdata = {ext_q, 8'b0};
  end

  assign cfg_stall  = hit_cmd && st != IDLE;
  assign mb_busy    = st != IDLE;
  assign mb_req_vld = st == ISSUE;
  assign mb_opcode  = op_q;
  assign mb_port    = port_q;
  assign mb_offset  = ofs_q;
  assign mb_be      = be_q;
  assign mb_wdata   = wd_q;
endmodule

// File: rtl/msgbus_bridge_chk.sv
module msgbus_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [7:0]  cfg_addr,
  input logic        cfg_stall,
  input logic        mb_busy,
  input logic        mb_req_vld,
  input logic        mb_req_rdy,
  input logic [7:0]  mb_opcode,
  input logic [7:0]  mb_port,
  input logic [31:0] mb_offset,
  input logic [3:0]  mb_be,
  input logic [31:0] mb_wdata
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req_vld && !mb_req_rdy |=> mb_req_vld);
  // R11
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req_vld && !mb_req_rdy |=> $stable(mb_opcode) && $stable(mb_port) &&
      $stable(mb_offset) && $stable(mb_be) && $stable(mb_wdata));
  // R5
  wdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req_vld && mb_opcode != 8'h11 |-> mb_wdata == 32'h0);
  // R9
  stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_stall |-> mb_busy);
  // R10
  vld_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req_vld |-> mb_busy);
  // R8
  no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mb_busy && (!cfg_wr || cfg_addr != 8'hD0) |=> !mb_busy);
endmodule

bind msgbus_cfg_bridge msgbus_bridge_chk i_chk (.*);

// File: tb/test_msgbus_cfg_bridge.sv
module test_msgbus_cfg_bridge;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, mb_req_rdy = 0, mb_rsp_vld = 0;
  logic [7:0] cfg_addr = 8'h00;
  logic [31:0] cfg_wdata = 0, mb_rsp_data = 0;
  logic [31:0] cfg_rdata, mb_offset, mb_wdata;
  logic cfg_stall, mb_busy, mb_req_vld;
  logic [7:0] mb_opcode, mb_port;
  logic [3:0] mb_be;
  int vectors = 0, errors = 0;

  always #5 clk = ~clk;

  msgbus_cfg_bridge i_msgbus_cfg_bridge (.*);

  int m_st = 0;
  logic [31:0] m_cmd = 0, m_box = 0, m_ext = 0;
  logic [31:0] m_op = 0, m_port = 0, m_ofs = 0, m_be = 0, m_wd = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cmd = 0; m_box = 0; m_ext = 0;
      m_op = 0; m_port = 0; m_ofs = 0; m_be = 0; m_wd = 0;
    end else begin
      int ns = m_st;
      logic [31:0] nbox = m_box;
      if (cfg_wr && cfg_addr == 8'hD4) nbox = cfg_wdata;
      if (m_st == 2 && mb_rsp_vld) begin
        if (m_op == 32'h10) nbox = mb_rsp_data;
        ns = 0;
      end
      if (m_st == 1 && mb_req_rdy) ns = 2;
      if (m_st == 0 && cfg_wr && cfg_addr == 8'hD0) begin
        m_cmd = cfg_wdata & 32'hFFFF_FFF0;
        m_op = cfg_wdata >> 24;
        m_port = (cfg_wdata >> 16) & 32'hFF;
        m_ofs = m_ext | ((cfg_wdata >> 8) & 32'hFF);
        m_be = (cfg_wdata >> 4) & 32'hF;
        m_wd = (m_op == 32'h11) ? m_box : 0;
        ns = 1;
      end
      if (cfg_wr && cfg_addr == 8'hD8) m_ext = cfg_wdata & 32'hFFFF_FF00;
      m_box = nbox;
      m_st = ns;
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [31:0] er;
    er = 0;
    if (cfg_addr == 8'hD0) er = m_cmd;
    else if (cfg_addr == 8'hD4) er = m_box;
    else if (cfg_addr == 8'hD8) er = m_ext;
    cmp("R1/R2/R6/R7 rdata", cfg_rdata, er);
    cmp("R9 stall", {31'b0, cfg_stall}, {31'b0, cfg_wr && cfg_addr == 8'hD0 && m_st != 0});
    cmp("R8/R10 busy", {31'b0, mb_busy}, {31'b0, m_st != 0});
    cmp("R3 req_vld", {31'b0, mb_req_vld}, {31'b0, m_st == 1});
    if (m_st == 1) begin
      cmp("R4/R11 opcode", {24'b0, mb_opcode}, m_op);
      cmp("R4/R11 port", {24'b0, mb_port}, m_port);
      cmp("R4/R11 offset", mb_offset, m_ofs);
      cmp("R4/R11 be", {28'b0, mb_be}, m_be);
      cmp("R5 wdata", mb_wdata, m_wd);
    end
  endtask

  task automatic step(logic wr, logic [7:0] a, logic [31:0] wd,
                      logic rdy, logic rv, logic [31:0] rd);
    @(negedge clk);
    compare_all();
    cfg_wr = wr; cfg_addr = a; cfg_wdata = wd;
    mb_req_rdy = rdy; mb_rsp_vld = rv; mb_rsp_data = rd;
  endtask

  task automatic rd(logic [7:0] a);
    step(0, a, 0, 0, 0, 0);
    step(0, a, 0, 0, 0, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(8'hD0); rd(8'hD4); rd(8'hD8);
    // R8 extension and mailbox writes do not launch; R2 masks
    step(1, 8'hD8, 32'h1234_5678, 0, 0, 0);
    step(1, 8'hD4, 32'hCAFE_F00D, 0, 0, 0);
    rd(8'hD8); rd(8'hD4);
    // R2 unused offset
    step(1, 8'h40, 32'hFFFF_FFFF, 0, 0, 0);
    rd(8'h40); rd(8'hD0);
    // R3 R4 R5 write opcode, ready withheld
    step(1, 8'hD0, 32'h1105_3CFF, 0, 0, 0);
    step(0, 8'hD0, 0, 0, 0, 0);
    step(0, 8'hD0, 0, 0, 0, 0);
    // R11 rewrite mailbox and extension during transaction
    step(1, 8'hD4, 32'h0000_0001, 0, 0, 0);
    step(1, 8'hD8, 32'hABCD_EF99, 0, 0, 0);
    step(0, 8'hD0, 0, 1, 0, 0);
    // R9 stalled command
    step(1, 8'hD0, 32'h1077_7777, 0, 0, 0);
    step(0, 8'hD0, 0, 0, 0, 0);
    // R7 write response leaves mailbox
    step(0, 8'hD4, 0, 0, 1, 32'hDEAD_BEEF);
    rd(8'hD4);
    // R6 read opcode, immediate accept, response races a mailbox write
    step(1, 8'hD0, 32'h1022_4430, 1, 0, 0);
    step(0, 8'hD4, 0, 1, 0, 0);
    step(1, 8'hD4, 32'h5555_5555, 0, 1, 32'hA5A5_0001);
    rd(8'hD4);
    // R10 stray response while idle
    step(0, 8'hD4, 0, 0, 1, 32'h0BAD_0BAD);
    rd(8'hD4);
    // R7 unknown opcode passes through, no data
    step(1, 8'hD0, 32'h0799_0810, 1, 0, 0);
    step(0, 8'hD4, 0, 0, 0, 0);
    step(0, 8'hD4, 0, 0, 1, 32'h7777_7777);
    rd(8'hD4); rd(8'hD0);
    step(0, 8'hD0, 0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule